// File: doc/BRIEF.md
# Peripheral Privilege Gate

This block stands in the request path between the bus masters and a region of peripheral address space. Every request carries a master number, a supervisor/user attribute, a direction, an address and write data. The gate picks the target slot from a field of the address. It then judges the request against two sets of rights: a small privilege setting per master, and an access nibble per peripheral slot. A request that passes goes to the target unchanged. A request that fails is consumed at once with an error flag, and the target sees no valid.

Each denied request is recorded in a fault log. The log holds the address, the master number and the direction of the latest fault. For write faults it also holds the rejected write data. The rights registers are loaded through a plain one-cycle configuration port. The rights registers and the fault log both clear to zero on reset, and with all rights zero every access is let through.

The request side and the target side are valid/ready streams. A request is accepted in the cycle where `req_valid` and `req_ready` are both high. For a permitted request, `req_ready` follows `tgt_ready`, so back-pressure from the target holds the requester. For a denied request, `req_ready` is high and `req_err` is high in the same cycle, whatever `tgt_ready` is. The requester must hold its fields stable while `req_valid` is high and `req_ready` is low.

Top module: `periph_priv_gate`

## Requirements
- R1: After reset, every slot nibble, every master setting and every fault-log field reads as zero, and every request is permitted.
- R2: The target slot is `req_addr[17:14]`. A permitted request raises `tgt_valid` and copies master, attribute, direction, address and data to the target side unchanged. `tgt_slot` carries the slot index.
- R3: A denied request keeps `tgt_valid` low and raises both `req_ready` and `req_err` in the same cycle, regardless of `tgt_ready`.
- R4: When bit 1 of a slot nibble (write-protect) is set, a write to that slot is denied at any privilege level. Reads of that slot are unaffected by this bit.
- R5: When bit 2 of a slot nibble (supervisor-only) is set, any request to that slot judged at user level is denied, whether it reads or writes.
- R6: When bit 0 of a slot nibble (trust) is set, the level is supervisor only if `req_sup`=1, master bit 1 (may-supervise)=1 and master bit 0 (force-user)=0. When bit 0 is clear, `req_sup` is taken as presented.
- R7: A denied request loads the fault log at the accepting edge with its address, master and direction (`flt_write`=1 for a write). `flt_data` is loaded with the write data only when the denied request is a write; a read fault leaves `flt_data` unchanged.
- R8: Permitted requests and idle cycles leave every fault-log field unchanged.
- R9: A cycle with `cfg_wr`=1 writes `cfg_val` at the next edge. It writes slot `cfg_idx` when `cfg_slot`=1. It writes master `cfg_idx` (low two bits of `cfg_val`) when `cfg_slot`=0 and `cfg_idx` < 4; otherwise the master write is ignored.
- R10: While a permitted request meets `tgt_ready`=0, `req_ready` and `req_err` stay low and `tgt_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Rights register write strobe |
| cfg_slot | input | 1 | 1 selects a slot nibble, 0 selects a master setting |
| cfg_idx | input | 4 | Slot or master index |
| cfg_val | input | 4 | Value to write |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted (forwarded or aborted) |
| req_mid | input | 2 | Master number |
| req_sup | input | 1 | Supervisor attribute |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 32 | Address |
| req_wdata | input | 32 | Write data |
| req_err | output | 1 | Request aborted with error |
| tgt_valid | output | 1 | Forwarded request valid |
| tgt_ready | input | 1 | Target ready |
| tgt_slot | output | 4 | Decoded slot index |
| tgt_mid | output | 2 | Forwarded master number |
| tgt_sup | output | 1 | Forwarded attribute |
| tgt_write | output | 1 | Forwarded direction |
| tgt_addr | output | 32 | Forwarded address |
| tgt_wdata | output | 32 | Forwarded write data |
| flt_addr | output | 32 | Address of latest fault |
| flt_mid | output | 2 | Master of latest fault |
| flt_write | output | 1 | Latest fault was a write |
| flt_data | output | 32 | Write data of latest write fault |

## Verification
The assertions check four things on every cycle. An error response never comes with a forwarded valid. Write-protect and supervisor-only denials always fire when their conditions are met. Each fault loads the log with the address it was accepted with. The log holds still when no fault occurs. Only the bench scenarios can show the full picture. They cover the trust-bit interaction with each master setting and the exact field values passed through. They also cover the configuration port actually changing a decision, and the split where a read fault updates the location but not the data.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned MPRV_W = 2;

  typedef struct packed {
    logic rsvd;
    logic sup_only;
    logic wprot;
    logic trust;
  } slot_acc_t;

  typedef struct packed {
    logic may_sup;
    logic force_user;
  } mst_priv_t;
endpackage

// File: rtl/ppg_rights_regs.sv
module ppg_rights_regs
  import ppg_pkg::*;
#(
  parameter int unsigned NUM_MST = 4,
  parameter int unsigned NUM_SLOT = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_slot,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [NIB_W-1:0] cfg_val,
  output slot_acc_t        slot_q [NUM_SLOT],
  output mst_priv_t        mst_q  [NUM_MST]
);
  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q[s] <= '0;
      else if (cfg_wr && cfg_slot && (cfg_idx == IDX_W'(s))) slot_q[s] <= slot_acc_t'(cfg_val);
    end
  end

  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    always_ff @(posedge clk) begin
      if (!rst_n) mst_q[m] <= '0;
      else if (cfg_wr && !cfg_slot && (cfg_idx == IDX_W'(m))) mst_q[m] <= mst_priv_t'(cfg_val[MPRV_W-1:0]);
    end
  end

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(slot_q[0]) && $stable(mst_q[0])); // R9
endmodule

// File: rtl/ppg_rule_eval.sv
module ppg_rule_eval
  import ppg_pkg::*;
#(
  parameter int unsigned NUM_MST = 4,
  parameter int unsigned MID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [MID_W-1:0] req_mid,
  input  logic             req_sup,
  input  logic             req_write,
  input  slot_acc_t        acc,
  input  mst_priv_t        mst_q [NUM_MST],
  output logic             deny
);
  mst_priv_t mp;
  logic      lvl_sup;

  always_comb begin
    mp = mst_q[req_mid];
    if (acc.trust) lvl_sup = req_sup && mp.may_sup && !mp.force_user;
    else           lvl_sup = req_sup;
    deny = (acc.sup_only && !lvl_sup) || (acc.wprot && req_write);
  end

  AST_WPROT_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && acc.wprot) |-> deny); // R4
  AST_USER_SUPONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc.sup_only && !req_sup) |-> deny); // R5
endmodule

// File: rtl/ppg_fault_log.sv
module ppg_fault_log #(
  parameter int unsigned MID_W = 2,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              cap_write,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [MID_W-1:0]  cap_mid,
  input  logic [DATA_W-1:0] cap_data,
  output logic [ADDR_W-1:0] flt_addr,
  output logic [MID_W-1:0]  flt_mid,
  output logic              flt_write,
  output logic [DATA_W-1:0] flt_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_addr  <= '0;
      flt_mid   <= '0;
      flt_write <= 1'b0;
      flt_data  <= '0;
    end else if (cap_en) begin
      flt_addr  <= cap_addr;
      flt_mid   <= cap_mid;
      flt_write <= cap_write;
      if (cap_write) flt_data <= cap_data;
    end
  end

  AST_FLT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (flt_addr == $past(cap_addr)) && (flt_mid == $past(cap_mid))); // R7
  AST_FLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(flt_addr) && $stable(flt_data) && $stable(flt_write)); // R8
endmodule

// File: rtl/periph_priv_gate.sv
module periph_priv_gate
  import ppg_pkg::*;
#(
  parameter int unsigned NUM_MST  = 4,
  parameter int unsigned SLOT_W   = 4,
  parameter int unsigned SLOT_LSB = 14,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned NUM_SLOT = 1 << SLOT_W,
  localparam int unsigned MID_W    = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_slot,
  input  logic [SLOT_W-1:0] cfg_idx,
  input  logic [NIB_W-1:0]  cfg_val,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MID_W-1:0]  req_mid,
  input  logic              req_sup,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_err,
  output logic              tgt_valid,
  input  logic              tgt_ready,
  output logic [SLOT_W-1:0] tgt_slot,
  output logic [MID_W-1:0]  tgt_mid,
  output logic              tgt_sup,
  output logic              tgt_write,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_wdata,
  output logic [ADDR_W-1:0] flt_addr,
  output logic [MID_W-1:0]  flt_mid,
  output logic              flt_write,
  output logic [DATA_W-1:0] flt_data
);
  slot_acc_t         slot_q [NUM_SLOT];
  mst_priv_t         mst_q  [NUM_MST];
  logic [SLOT_W-1:0] slot_idx;
  slot_acc_t         acc_sel;
  logic              deny;

  ppg_rights_regs #(
    .NUM_MST (NUM_MST),
    .NUM_SLOT(NUM_SLOT),
    .IDX_W   (SLOT_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (cfg_wr),
    .cfg_slot(cfg_slot),
    .cfg_idx (cfg_idx),
    .cfg_val (cfg_val),
    .slot_q  (slot_q),
    .mst_q   (mst_q)
  );

  assign slot_idx = req_addr[SLOT_LSB +: SLOT_W];
  assign acc_sel  = slot_q[slot_idx];

  ppg_rule_eval #(
    .NUM_MST(NUM_MST),
    .MID_W  (MID_W)
  ) u_rule (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_mid  (req_mid),
    .req_sup  (req_sup),
    .req_write(req_write),
    .acc      (acc_sel),
    .mst_q    (mst_q),
    .deny     (deny)
  );

  always_comb begin
    tgt_valid = req_valid && !deny;
    req_err   = req_valid && deny;
    req_ready = deny ? 1'b1 : tgt_ready;
    tgt_slot  = slot_idx;
    tgt_mid   = req_mid;
    tgt_sup   = req_sup;
    tgt_write = req_write;
    tgt_addr  = req_addr;
    tgt_wdata = req_wdata;
  end

  ppg_fault_log #(
    .MID_W (MID_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_log (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (req_err),
    .cap_write(req_write),
    .cap_addr (req_addr),
    .cap_mid  (req_mid),
    .cap_data (req_wdata),
    .flt_addr (flt_addr),
    .flt_mid  (flt_mid),
    .flt_write(flt_write),
    .flt_data (flt_data)
  );

  AST_ERR_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!tgt_valid && req_ready)); // R3
  AST_STALL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && !tgt_ready) |-> (!req_ready && !req_err)); // R10
endmodule

// File: tb/periph_priv_gate_tb.sv
module periph_priv_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_slot = 1'b0;
  logic [3:0]  cfg_idx = '0, cfg_val = '0;
  logic        req_valid = 1'b0, req_sup = 1'b0, req_write = 1'b0, tgt_ready = 1'b1;
  logic [1:0]  req_mid = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, req_err, tgt_valid, tgt_sup, tgt_write, flt_write;
  logic [3:0]  tgt_slot;
  logic [1:0]  tgt_mid, flt_mid;
  logic [31:0] tgt_addr, tgt_wdata, flt_addr, flt_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] sh_slot [16];
  logic [1:0] sh_mst [4];

  always #2.5 clk = ~clk;

  periph_priv_gate dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_slot(cfg_slot), .cfg_idx(cfg_idx),
    .cfg_val(cfg_val), .req_valid(req_valid), .req_ready(req_ready), .req_mid(req_mid),
    .req_sup(req_sup), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_err(req_err), .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_slot(tgt_slot),
    .tgt_mid(tgt_mid), .tgt_sup(tgt_sup), .tgt_write(tgt_write), .tgt_addr(tgt_addr),
    .tgt_wdata(tgt_wdata), .flt_addr(flt_addr), .flt_mid(flt_mid), .flt_write(flt_write),
    .flt_data(flt_data)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model_deny(logic [1:0] mid, bit sup, bit wr, logic [31:0] addr);
    logic [3:0] n = sh_slot[addr[17:14]];
    logic [1:0] m = sh_mst[mid];
    bit lvl = n[0] ? (sup && m[1] && !m[0]) : sup;
    return (n[2] && !lvl) || (n[1] && wr);
  endfunction

  task automatic cfg(bit is_slot, logic [3:0] idx, logic [3:0] val);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_slot = is_slot; cfg_idx = idx; cfg_val = val;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (is_slot) sh_slot[idx] = val;
    else if (idx < 4) sh_mst[idx[1:0]] = val[1:0];
  endtask

  // drives a request, checks the accept-cycle outputs against the model, completes it
  task automatic access(string req, logic [1:0] mid, bit sup, bit wr, logic [31:0] addr,
                        logic [31:0] data, bit trdy);
    bit d;
    @(negedge clk);
    req_valid = 1'b1; req_mid = mid; req_sup = sup; req_write = wr;
    req_addr = addr; req_wdata = data; tgt_ready = trdy;
    #1;
    d = model_deny(mid, sup, wr, addr);
    chk({req, " err"}, 64'(req_err), 64'(d));
    chk({req, " tvalid"}, 64'(tgt_valid), 64'(!d));
    chk({req, " ready"}, 64'(req_ready), 64'(d ? 1'b1 : trdy));
    @(negedge clk);
    req_valid = 1'b0; tgt_ready = 1'b1;
    #1;
  endtask

  task automatic t_reset;
    chk("R1 flt_addr", 64'(flt_addr), 0);
    chk("R1 flt_data", 64'(flt_data), 0);
    chk("R1 flt_mid/write", 64'({flt_mid, flt_write}), 0);
    access("R1 user write slot 9", 2'd3, 1'b0, 1'b1, 32'h0002_4000, 32'h1111_2222, 1'b1);
    access("R1 user read slot 0", 2'd0, 1'b0, 1'b0, 32'h0000_0004, 32'h0, 1'b1);
  endtask

  task automatic t_pass;
    @(negedge clk);
    req_valid = 1'b1; req_mid = 2'd2; req_sup = 1'b1; req_write = 1'b1;
    req_addr = 32'hA003_C010; req_wdata = 32'hDEAD_BEEF; tgt_ready = 1'b1;
    #1;
    chk("R2 tgt_valid", 64'(tgt_valid), 1);
    chk("R2 tgt_slot", 64'(tgt_slot), 64'hF);
    chk("R2 tgt_addr", 64'(tgt_addr), 64'hA003_C010);
    chk("R2 tgt_wdata", 64'(tgt_wdata), 64'hDEAD_BEEF);
    chk("R2 tgt_mid/sup/write", 64'({tgt_mid, tgt_sup, tgt_write}), 64'b1011);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_backpressure;
    access("R10 stalled", 2'd1, 1'b0, 1'b0, 32'h0000_8000, 32'h0, 1'b0);
    chk("R8 log after ok", 64'(flt_addr), 0);
  endtask

  task automatic t_wprot;
    cfg(1'b1, 4'd3, 4'h2);
    access("R4 sup write wprot", 2'd1, 1'b1, 1'b1, 32'h0000_C000, 32'h5A5A_0001, 1'b1);
    chk("R7 flt_data wprot", 64'(flt_data), 64'h5A5A_0001);
    access("R4 read wprot ok", 2'd1, 1'b0, 1'b0, 32'h0000_C000, 32'h0, 1'b1);
    access("R3 denied under stall", 2'd0, 1'b1, 1'b1, 32'h0000_C008, 32'h7, 1'b0);
  endtask

  task automatic t_suponly;
    cfg(1'b1, 4'd5, 4'h4);
    access("R5 user read suponly", 2'd0, 1'b0, 1'b0, 32'h0001_4000, 32'h0, 1'b1);
    access("R5 user write suponly", 2'd0, 1'b0, 1'b1, 32'h0001_4004, 32'h9, 1'b1);
    access("R5 sup read suponly", 2'd0, 1'b1, 1'b0, 32'h0001_4000, 32'h0, 1'b1);
  endtask

  task automatic t_trust;
    cfg(1'b1, 4'd6, 4'h5);
    access("R6 trust no priv", 2'd2, 1'b1, 1'b0, 32'h0001_8000, 32'h0, 1'b1);
    cfg(1'b0, 4'd2, 4'h2);
    access("R6 R9 trust may_sup", 2'd2, 1'b1, 1'b0, 32'h0001_8000, 32'h0, 1'b1);
    cfg(1'b0, 4'd2, 4'h3);
    access("R6 trust force_user", 2'd2, 1'b1, 1'b0, 32'h0001_8000, 32'h0, 1'b1);
    cfg(1'b0, 4'd9, 4'h2);
    access("R9 bad master idx ignored", 2'd1, 1'b1, 1'b0, 32'h0001_8000, 32'h0, 1'b1);
  endtask

  task automatic t_fault_log;
    cfg(1'b1, 4'd7, 4'h6);
    access("R7 write fault", 2'd3, 1'b0, 1'b1, 32'h0001_C0F0, 32'hCAFE_0007, 1'b1);
    chk("R7 flt_addr w", 64'(flt_addr), 64'h0001_C0F0);
    chk("R7 flt_mid w", 64'(flt_mid), 3);
    chk("R7 flt_write w", 64'(flt_write), 1);
    chk("R7 flt_data w", 64'(flt_data), 64'hCAFE_0007);
    access("R7 read fault", 2'd1, 1'b0, 1'b0, 32'h0001_C0A0, 32'h1234_5678, 1'b1);
    chk("R7 flt_addr r", 64'(flt_addr), 64'h0001_C0A0);
    chk("R7 flt_mid r", 64'(flt_mid), 1);
    chk("R7 flt_write r", 64'(flt_write), 0);
    chk("R7 flt_data kept", 64'(flt_data), 64'hCAFE_0007);
    access("R8 ok access", 2'd0, 1'b1, 1'b0, 32'h0001_C000, 32'h0, 1'b1);
    chk("R8 flt_addr kept", 64'(flt_addr), 64'h0001_C0A0);
    chk("R8 flt_data kept", 64'(flt_data), 64'hCAFE_0007);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) sh_slot[i] = '0;
    for (int i = 0; i < 4; i++) sh_mst[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_pass();
    t_backpressure();
    t_wprot();
    t_suponly();
    t_trust();
    t_fault_log();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule